// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block looks at two decoded integer instructions that arrive in program order, an older one (slot A) and a younger one (slot B). It decides whether both can enter the two execution pipes in the same clock or whether only slot A may go. Each slot carries a descriptor made of a class code, register masks, flag-use bits, a memory-operand bit and a read-modify-write bit. One clock after a valid strobe, the block reports three results: whether the two may pair, how many instructions issue (1 or 2), and how many execute clocks the issued group needs, sequencing penalties included.

Only the simple instruction classes may pair, and some of them only in one slot. A register dependency from A to B blocks pairing, and so does a flag dependency. Two cases are exempt: a compare followed by a conditional branch, and two pushes or two pops that share only the stack pointer. When both instructions of a pair are read-modify-write operations, the group pays extra sequencing clocks.

Top module: `pair_issue_check`

## Requirements
- R1: Class codes are: 0 move to register, 1 store to memory, 2 ALU with register destination, 3 ALU with memory destination, 4 increment, 5 decrement, 6 push, 7 pop, 8 address computation, 9 near jump/call, 10 conditional branch, 11 no-op, 12 simple shift/rotate, 13 add-with-carry/subtract-with-borrow, 14 compare, 15 complex. A complex class in either slot forces single issue. `issue_cnt` is 2 when `pair_ok` is 1, otherwise 1.
- R2: Class 9 or 10 in slot A forces single issue. In slot B, either class may pair.
- R3: Class 12 may pair only from slot A. In slot B it forces single issue.
- R4: If slot B reads (`b_src`) or writes (`b_dst`) any register bit that slot A writes (`a_dst`), the two do not pair. A register that B writes and A does not write never blocks pairing.
- R5: If A writes flags (`a_flag_wr`) and B reads flags (`b_flag_rd`), the two do not pair. An example is an ALU operation followed by an add-with-carry.
- R6: A compare (class 14) in slot A followed by a conditional branch (class 10) in slot B pairs despite the flag dependency. No other class in slot A gets this exemption.
- R7: Push/push and pop/pop pairs ignore overlap on the stack-pointer bit (bit SP_BIT, default 4). Overlap on any other bit still blocks them. A push paired with a pop gets no exemption.
- R8: One instruction takes 3 execute clocks when its read-modify-write bit is set. It takes 2 clocks when it is class 2, 13 or 14 with its memory bit set. Every other instruction takes 1 clock.
- R9: A paired group takes the larger of the two clock counts. When both slots are read-modify-write, it takes 3 + RMW_EXTRA clocks instead (5 by default).
- R10: When `b_valid` is 0, or pairing is refused, the block issues one instruction, and `exec_clks` is the slot A count alone.
- R11: The results appear on the clock edge that samples `in_valid` high. `out_valid` follows `in_valid` one clock later.
- R12: An active-low synchronous reset clears `out_valid`, `pair_ok`, `issue_cnt` and `exec_clks` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor pair valid strobe |
| a_cls | input | 4 | Slot A class code |
| a_dst | input | REG_W | Slot A written-register mask |
| a_flag_wr | input | 1 | Slot A writes flags |
| a_mem | input | 1 | Slot A has a memory operand |
| a_rmw | input | 1 | Slot A is read-modify-write |
| b_valid | input | 1 | Slot B holds an instruction |
| b_cls | input | 4 | Slot B class code |
| b_src | input | REG_W | Slot B read-register mask |
| b_dst | input | REG_W | Slot B written-register mask |
| b_flag_rd | input | 1 | Slot B reads flags |
| b_mem | input | 1 | Slot B has a memory operand |
| b_rmw | input | 1 | Slot B is read-modify-write |
| out_valid | output | 1 | Result valid |
| pair_ok | output | 1 | Both slots issue together |
| issue_cnt | output | 2 | Instructions issued (1 or 2) |
| exec_clks | output | CLK_W | Execute clocks for the issued group |

## Verification
Every result of this block (the pair decision, the issue count and the clock count) is due exactly one rising edge after the cycle in which `in_valid` is driven high. The driver applies stimulus on the falling edge and pushes the expected triple into a queue. A monitor wakes one nanosecond after each rising edge. It requires `out_valid` to be high exactly when an item is waiting, and then compares all three results. A late, early or missing result is therefore caught at once.

// File: rtl/pair_pkg.sv
package pair_pkg;
   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CL_MOV_LD = 4'd0,
      CL_MOV_ST = 4'd1,
      CL_ALU_R  = 4'd2,
      CL_ALU_M  = 4'd3,
      CL_INC    = 4'd4,
      CL_DEC    = 4'd5,
      CL_PUSH   = 4'd6,
      CL_POP    = 4'd7,
      CL_LEA    = 4'd8,
      CL_JMP    = 4'd9,
      CL_JCC    = 4'd10,
      CL_NOP    = 4'd11,
      CL_SHIFT  = 4'd12,
      CL_CARRY  = 4'd13,
      CL_CMP    = 4'd14,
      CL_CPLX   = 4'd15
   } cls_e;

   function automatic logic is_branch(cls_e c);
      return (c == CL_JMP) || (c == CL_JCC);
   endfunction

   function automatic logic is_alu_reg(cls_e c);
      return (c == CL_ALU_R) || (c == CL_CARRY) || (c == CL_CMP);
   endfunction
endpackage

// File: rtl/pair_slot_rules.sv
module pair_slot_rules
   import pair_pkg::*;
#(
   parameter bit SLOT_B = 1'b0
) (
   input  cls_e cls,
   output logic eligible
);
   logic simple;
   assign simple = (cls != CL_CPLX);

   generate
      if (SLOT_B) begin : g_second
         // younger slot: branches fine, shifts refused
         assign eligible = simple && (cls != CL_SHIFT);
      end else begin : g_first
         // older slot: shifts fine, branches refused
         assign eligible = simple && !is_branch(cls);
      end
   endgenerate
endmodule

// File: rtl/pair_clk_calc.sv
module pair_clk_calc
   import pair_pkg::*;
#(
   parameter int CLK_W = 3
) (
   input  cls_e             cls,
   input  logic             mem,
   input  logic             rmw,
   output logic [CLK_W-1:0] clks
);
   always_comb begin
      if (rmw)                        clks = CLK_W'(3);
      else if (mem && is_alu_reg(cls)) clks = CLK_W'(2);
      else                            clks = CLK_W'(1);
   end
endmodule

// File: rtl/pair_dep_check.sv
module pair_dep_check
   import pair_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter int SP_BIT        = 4,
   parameter bit STACK_PAIR_EN = 1'b1
) (
   input  cls_e             a_cls,
   input  cls_e             b_cls,
   input  logic [REG_W-1:0] a_dst,
   input  logic [REG_W-1:0] b_src,
   input  logic [REG_W-1:0] b_dst,
   input  logic             a_flag_wr,
   input  logic             b_flag_rd,
   output logic             hazard
);
   localparam logic [REG_W-1:0] SP_MASK = REG_W'(1) << SP_BIT;

   logic             like_stack;
   logic [REG_W-1:0] ignore_mask;
   logic [REG_W-1:0] overlap;
   logic             flag_dep;

   assign like_stack = ((a_cls == CL_PUSH) && (b_cls == CL_PUSH)) ||
                       ((a_cls == CL_POP)  && (b_cls == CL_POP));

   generate
      if (STACK_PAIR_EN) begin : g_stack_ex
         assign ignore_mask = like_stack ? SP_MASK : '0;
      end else begin : g_no_stack_ex
         assign ignore_mask = '0;
      end
   endgenerate

   // read-after-write and write-after-write on register bits
   assign overlap  = a_dst & (b_src | b_dst) & ~ignore_mask;
   assign flag_dep = a_flag_wr && b_flag_rd &&
                     !((a_cls == CL_CMP) && (b_cls == CL_JCC));
   assign hazard   = (|overlap) || flag_dep;
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
   import pair_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter int SP_BIT        = 4,
   parameter int RMW_EXTRA     = 2,
   parameter int CLK_W         = 3,
   parameter bit STACK_PAIR_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [CLS_W-1:0]     a_cls,
   input  logic [REG_W-1:0]     a_dst,
   input  logic                 a_flag_wr,
   input  logic                 a_mem,
   input  logic                 a_rmw,
   input  logic                 b_valid,
   input  logic [CLS_W-1:0]     b_cls,
   input  logic [REG_W-1:0]     b_src,
   input  logic [REG_W-1:0]     b_dst,
   input  logic                 b_flag_rd,
   input  logic                 b_mem,
   input  logic                 b_rmw,
   output logic                 out_valid,
   output logic                 pair_ok,
   output logic [1:0]           issue_cnt,
   output logic [CLK_W-1:0]     exec_clks
);
   localparam int               RMW_PAIR = 3 + RMW_EXTRA;
   localparam logic [CLK_W-1:0] RMW_PAIR_CLKS = CLK_W'(RMW_PAIR);

   generate
      if (SP_BIT >= REG_W) begin : g_bad_sp
         $error("SP_BIT must index into the register mask");
      end
      if ((1 << CLK_W) <= RMW_PAIR) begin : g_bad_clkw
         $error("CLK_W too narrow for paired read-modify-write count");
      end
      if (RMW_EXTRA < 0) begin : g_bad_extra
         $error("RMW_EXTRA must not be negative");
      end
   endgenerate

   cls_e a_c, b_c;
   assign a_c = cls_e'(a_cls);
   assign b_c = cls_e'(b_cls);

   logic [1:0]       slot_ok;
   logic [CLK_W-1:0] slot_clks [2];
   cls_e             slot_cls  [2];
   logic             slot_mem  [2];
   logic             slot_rmw  [2];

   assign slot_cls[0] = a_c;  assign slot_cls[1] = b_c;
   assign slot_mem[0] = a_mem; assign slot_mem[1] = b_mem;
   assign slot_rmw[0] = a_rmw; assign slot_rmw[1] = b_rmw;

   generate
      for (genvar s = 0; s < 2; s++) begin : g_slot
         pair_slot_rules #(.SLOT_B(s == 1)) u_rules (
            .cls      (slot_cls[s]),
            .eligible (slot_ok[s])
         );
         pair_clk_calc #(.CLK_W(CLK_W)) u_clk (
            .cls  (slot_cls[s]),
            .mem  (slot_mem[s]),
            .rmw  (slot_rmw[s]),
            .clks (slot_clks[s])
         );
      end
   endgenerate

   logic hazard;
   pair_dep_check #(
      .REG_W         (REG_W),
      .SP_BIT        (SP_BIT),
      .STACK_PAIR_EN (STACK_PAIR_EN)
   ) u_dep (
      .a_cls     (a_c),
      .b_cls     (b_c),
      .a_dst     (a_dst),
      .b_src     (b_src),
      .b_dst     (b_dst),
      .a_flag_wr (a_flag_wr),
      .b_flag_rd (b_flag_rd),
      .hazard    (hazard)
   );

   logic             pair_c;
   logic [CLK_W-1:0] clks_c;

   assign pair_c = b_valid && (&slot_ok) && !hazard;

   always_comb begin
      if (!pair_c)
         clks_c = slot_clks[0];
      else if (a_rmw && b_rmw)
         clks_c = RMW_PAIR_CLKS;
      else if (slot_clks[1] > slot_clks[0])
         clks_c = slot_clks[1];
      else
         clks_c = slot_clks[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pair_ok   <= 1'b0;
         issue_cnt <= 2'd0;
         exec_clks <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pair_ok   <= pair_c;
            issue_cnt <= pair_c ? 2'd2 : 2'd1;
            exec_clks <= clks_c;
         end
      end
   end

   // ---------------- assertions ----------------
   p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_count_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (issue_cnt == (pair_ok ? 2'd2 : 2'd1)));
   p_branch_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_branch(a_c)) |=> !pair_ok);
   p_shift_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && b_c == CL_SHIFT) |=> !pair_ok);
   p_cplx_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (a_c == CL_CPLX || b_c == CL_CPLX)) |=> !pair_ok);
   p_rmw_penalty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && a_rmw && b_rmw) |=> (!pair_ok || exec_clks == RMW_PAIR_CLKS));
   p_no_b_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !b_valid) |=> (!pair_ok && issue_cnt == 2'd1));
   p_reset_clear_r12: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && issue_cnt == 2'd0 && exec_clks == '0));
endmodule

// File: tb/tb_pair_issue_check.sv
`timescale 1ns/1ps
module tb_pair_issue_check;
   import pair_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       in_valid = 1'b0, b_valid = 1'b0;
   logic [3:0] a_cls = '0, b_cls = '0;
   logic [7:0] a_dst = '0, b_src = '0, b_dst = '0;
   logic       a_flag_wr = 1'b0, a_mem = 1'b0, a_rmw = 1'b0;
   logic       b_flag_rd = 1'b0, b_mem = 1'b0, b_rmw = 1'b0;
   logic       out_valid, pair_ok;
   logic [1:0] issue_cnt;
   logic [2:0] exec_clks;

   pair_issue_check dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_cls(a_cls), .a_dst(a_dst), .a_flag_wr(a_flag_wr), .a_mem(a_mem), .a_rmw(a_rmw),
      .b_valid(b_valid), .b_cls(b_cls), .b_src(b_src), .b_dst(b_dst),
      .b_flag_rd(b_flag_rd), .b_mem(b_mem), .b_rmw(b_rmw),
      .out_valid(out_valid), .pair_ok(pair_ok), .issue_cnt(issue_cnt), .exec_clks(exec_clks)
   );

   typedef struct packed {
      logic [3:0] cls;
      logic [7:0] src;
      logic [7:0] dst;
      logic       fr, fw, mem, rmw;
   } desc_t;

   typedef struct {
      logic       p;
      logic [2:0] c;
      string      tag;
   } exp_t;

   exp_t q[$];
   int tests = 0, fails = 0;
   bit done = 1'b0;

   function automatic desc_t mk(logic [3:0] cls, logic [7:0] src, logic [7:0] dst,
                                logic fr, logic fw, logic mem, logic rmw);
      desc_t d;
      d.cls = cls; d.src = src; d.dst = dst;
      d.fr = fr; d.fw = fw; d.mem = mem; d.rmw = rmw;
      return d;
   endfunction

   task automatic send(desc_t a, desc_t b, logic bv, logic ep, logic [2:0] ec, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      a_cls = a.cls; a_dst = a.dst; a_flag_wr = a.fw; a_mem = a.mem; a_rmw = a.rmw;
      b_valid = bv;
      b_cls = b.cls; b_src = b.src; b_dst = b.dst; b_flag_rd = b.fr; b_mem = b.mem; b_rmw = b.rmw;
      e.p = ep; e.c = ec; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: results due one edge after the strobe
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (!out_valid || pair_ok !== e.p || exec_clks !== e.c ||
                issue_cnt !== (e.p ? 2'd2 : 2'd1)) begin
               fails++;
               $display("FAIL %s: valid=%0b pair=%0b cnt=%0d clks=%0d expected valid=1 pair=%0b cnt=%0d clks=%0d",
                        e.tag, out_valid, pair_ok, issue_cnt, exec_clks,
                        e.p, (e.p ? 2 : 1), e.c);
            end
         end else if (out_valid !== 1'b0) begin
            tests++;
            fails++;
            $display("FAIL R11: out_valid=%b with nothing pending, expected 0", out_valid);
         end
      end
   end

   task automatic check_cleared(string tag);
      tests++;
      if (out_valid !== 1'b0 || pair_ok !== 1'b0 || issue_cnt !== 2'd0 || exec_clks !== 3'd0) begin
         fails++;
         $display("FAIL %s: valid=%b pair=%b cnt=%0d clks=%0d expected all zero",
                  tag, out_valid, pair_ok, issue_cnt, exec_clks);
      end
   endtask

   localparam logic [7:0] SP = 8'h10;

   initial begin
      desc_t nop;
      nop = mk(CL_NOP, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      check_cleared("R12 reset");
      rst_n = 1'b1;

      // R1: plain moves, complex class
      send(mk(CL_MOV_LD, 8'h02, 8'h01, 0,0,0,0), mk(CL_MOV_LD, 8'h08, 8'h04, 0,0,0,0), 1, 1, 1, "R1 mov pair");
      send(mk(CL_CPLX, 0, 8'h01, 0,0,0,0), nop, 1, 0, 1, "R1 complex A");
      send(nop, mk(CL_CPLX, 0, 8'h01, 0,0,0,0), 1, 0, 1, "R1 complex B");
      // R2: branches
      send(mk(CL_JCC, 0, 0, 1,0,0,0), nop, 1, 0, 1, "R2 jcc in A");
      send(mk(CL_JMP, 0, 0, 0,0,0,0), nop, 1, 0, 1, "R2 jmp in A");
      send(nop, mk(CL_JCC, 0, 0, 1,0,0,0), 1, 1, 1, "R2 jcc in B");
      send(nop, mk(CL_JMP, 0, 0, 0,0,0,0), 1, 1, 1, "R2 jmp in B");
      // R3: shifts
      send(mk(CL_SHIFT, 8'h01, 8'h01, 0,1,0,0), mk(CL_MOV_LD, 8'h04, 8'h02, 0,0,0,0), 1, 1, 1, "R3 shift in A");
      send(mk(CL_MOV_LD, 8'h04, 8'h02, 0,0,0,0), mk(CL_SHIFT, 8'h01, 8'h01, 0,1,0,0), 1, 0, 1, "R3 shift in B");
      // R4: register dependencies
      send(mk(CL_MOV_LD, 0, 8'h01, 0,0,0,0), mk(CL_ALU_R, 8'h01, 8'h02, 0,1,0,0), 1, 0, 1, "R4 raw");
      send(mk(CL_MOV_LD, 0, 8'h02, 0,0,0,0), mk(CL_MOV_LD, 8'h08, 8'h02, 0,0,0,0), 1, 0, 1, "R4 waw");
      send(mk(CL_ALU_R, 0, 8'h01, 0,1,0,0), mk(CL_ALU_R, 8'h02, 8'h04, 0,1,0,0), 1, 1, 1, "R4 independent");
      // R5/R6: flags
      send(mk(CL_ALU_R, 0, 8'h01, 0,1,0,0), mk(CL_CARRY, 8'h02, 8'h02, 1,1,0,0), 1, 0, 1, "R5 alu then carry");
      send(mk(CL_CMP, 8'h03, 0, 0,1,0,0), mk(CL_JCC, 0, 0, 1,0,0,0), 1, 1, 1, "R6 cmp jcc");
      send(mk(CL_ALU_R, 0, 8'h01, 0,1,0,0), mk(CL_JCC, 0, 0, 1,0,0,0), 1, 0, 1, "R6 alu jcc");
      // R7: stack pairs
      send(mk(CL_PUSH, 0, SP, 0,0,0,0), mk(CL_PUSH, 8'h12, SP, 0,0,0,0), 1, 1, 1, "R7 push push");
      send(mk(CL_POP, 0, SP|8'h01, 0,0,0,0), mk(CL_POP, SP, SP|8'h02, 0,0,0,0), 1, 1, 1, "R7 pop pop");
      send(mk(CL_PUSH, 0, SP, 0,0,0,0), mk(CL_POP, SP, SP|8'h02, 0,0,0,0), 1, 0, 1, "R7 push pop");
      send(mk(CL_POP, 0, SP|8'h01, 0,0,0,0), mk(CL_POP, SP, SP|8'h01, 0,0,0,0), 1, 0, 1, "R7 pop pop same reg");
      // R8/R9: timing
      send(mk(CL_ALU_R, 0, 8'h01, 0,1,1,0), nop, 1, 1, 2, "R8 alu reg,mem");
      send(mk(CL_CMP, 8'h01, 0, 0,1,1,0), nop, 1, 1, 2, "R8 cmp mem");
      send(mk(CL_ALU_M, 8'h01, 0, 0,1,1,1), nop, 1, 1, 3, "R8 rmw");
      send(mk(CL_MOV_LD, 0, 8'h02, 0,0,1,0), nop, 1, 1, 1, "R8 mov load");
      send(mk(CL_MOV_LD, 0, 8'h02, 0,0,0,0), mk(CL_ALU_M, 8'h01, 0, 0,1,1,1), 1, 1, 3, "R9 max of pair");
      send(mk(CL_ALU_M, 8'h01, 0, 0,1,1,1), mk(CL_ALU_M, 8'h02, 0, 0,1,1,1), 1, 1, 5, "R9 rmw pair");
      // R10: single issue
      send(mk(CL_ALU_M, 8'h01, 0, 0,1,1,1), nop, 0, 0, 3, "R10 b invalid");
      send(mk(CL_ALU_R, 0, 8'h01, 0,1,1,0), mk(CL_MOV_LD, 8'h01, 8'h02, 0,0,0,0), 1, 0, 2, "R10 refused keeps A clks");
      // R11: back-to-back strobes
      @(negedge clk);
      begin
         exp_t e1, e2;
         in_valid = 1'b1; b_valid = 1'b1;
         a_cls = CL_NOP; a_dst = 0; a_flag_wr = 0; a_mem = 0; a_rmw = 0;
         b_cls = CL_NOP; b_src = 0; b_dst = 0; b_flag_rd = 0; b_mem = 0; b_rmw = 0;
         e1.p = 1; e1.c = 1; e1.tag = "R11 back-to-back 1";
         q.push_back(e1);
         @(negedge clk);
         a_cls = CL_JCC;
         e2.p = 0; e2.c = 1; e2.tag = "R11 back-to-back 2";
         q.push_back(e2);
         @(negedge clk);
         in_valid = 1'b0;
      end
      // R12: reset during a strobe
      repeat (2) @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_cleared("R12 mid-run reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      tests++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R11: %0d results never appeared, expected 0", q.size());
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule